// File: doc/BRIEF.md
# Dual-Parallel Flash Command Router

This block sits between a single-channel serial flash command engine and two identical quad-lane flash devices that share one chip select and one serial clock. The engine sends a byte stream that carries start and end markers. The first byte of each frame is the opcode. The router latches it, sorts it into a command class, and from then on decides for each following byte how it reaches the two devices:

- The same byte can go to both devices.
- The byte's bits can be split between the two devices.
- The slot can be turned into a read.

For reads, the router rebuilds the returned byte for the receive stream. Status reads are handled differently: the router reads both devices and returns the bitwise OR of their two status bytes.

One serial clock period takes two system clocks. The clock is low in the first and high in the second. The router changes its lane outputs while the clock is low, and it samples the device lanes at the end of the high half.

For read classes, a configuration input sets a number of whole dummy bytes. The router inserts them after the address with the lanes released. One dummy byte lasts two serial clocks.

Top module: `dpr_router`

## Requirements
- R1: A frame opens only when a byte marked `tx_first` is accepted while the router is idle. A byte accepted while idle without that mark is dropped, and chip select and the serial clock stay inactive. The serial clock never pulses while chip select is high.
- R2: The opcode is sent to both devices on lane 0 only, most significant bit first, over 8 serial clocks. Lane output-enable is 4'b0001 on both devices.
- R3: For read opcodes (03h, 13h, 0Bh, 0Ch, 6Bh, EBh) and program opcodes (02h, 12h, 32h), the first ADDR_BYTES bytes after the opcode go to both devices on all four lanes. Each takes 2 serial clocks, high nibble first, and lane k carries nibble bit k.
- R4: After the address of a program opcode, each data byte takes one serial clock. Lower-device lane k carries bit 2k and upper-device lane k carries bit 2k+1.
- R5: After the address (and any dummy bytes) of a read opcode, each byte slot takes one serial clock with all lanes released. The returned byte has bit 2k from lower lane k and bit 2k+1 from upper lane k.
- R6: After the last address byte of a read opcode, the router inserts 2×N serial clocks with all lanes released and consumes no stream byte. N is `cfg_dummy_a` for 03h/13h and `cfg_dummy_b` for 0Bh/0Ch/6Bh/EBh.
- R7: For erase opcodes (20h, 52h, D8h, 60h, C7h), every byte after the opcode goes to both devices, as in R3.
- R8: For status opcodes (05h, 70h), every byte slot after the opcode is a 2-clock read from both devices, high nibble first. The returned byte is the bitwise OR of the two devices' bytes.
- R9: For any other opcode, a byte with `tx_rd` low goes to both devices, as in R3. A byte with `tx_rd` high becomes a 2-clock read whose returned byte comes from the lower device alone.
- R10: Chip select rises as soon as the slot of the byte marked `tx_last` ends. At that point `tx_ready` is high, and the latched opcode class is cleared.
- R11: For the read, program, erase and status classes, `tx_rd` has no effect on lane timing or values.
- R12: After reset, chip select is high, the serial clock is low, all lane enables are 0, `rx_valid` is 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Stream byte offered |
| tx_ready | output | 1 | Router accepts the offered byte this cycle |
| tx_data | input | 8 | Stream byte |
| tx_first | input | 1 | Byte opens a frame (opcode) |
| tx_last | input | 1 | Byte closes the frame |
| tx_rd | input | 1 | Byte slot is a read (honoured for unclassified opcodes only) |
| cfg_dummy_a | input | DUMMY_W | Dummy byte count for opcodes 03h/13h |
| cfg_dummy_b | input | DUMMY_W | Dummy byte count for opcodes 0Bh/0Ch/6Bh/EBh |
| cs_n | output | 1 | Shared chip select, active low |
| sck | output | 1 | Shared serial clock |
| lo_dq_o | output | 4 | Lower device lane outputs |
| lo_dq_oe | output | 4 | Lower device lane output enables |
| lo_dq_i | input | 4 | Lower device lane inputs |
| hi_dq_o | output | 4 | Upper device lane outputs |
| hi_dq_oe | output | 4 | Upper device lane output enables |
| hi_dq_i | input | 4 | Upper device lane inputs |
| rx_valid | output | 1 | Returned byte valid (one-cycle pulse) |
| rx_data | output | 8 | Returned byte |

## Verification
A wrongly latched class or byte index shows at once on the lanes. The split, duplicated or released pattern changes on the very next serial clock, and the number of clocks per frame shifts. A wrong dummy count shifts every later read by whole clock periods, so every returned byte of the frame differs. A bad nibble hold or merge register shows on the first returned byte, one system clock after its slot ends. The devices are modelled as driving a value that depends on the serial clock index within the frame, so each returned byte is tied to the exact clock it was sampled in.

// File: rtl/dpr_pkg.sv
// Shared types and opcode classification for the dual-parallel flash router.
// Assumes four data lanes per device; the bit split depends on that count.
package dpr_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        CL_NONE, CL_RD_A, CL_RD_B, CL_PROG, CL_ERASE, CL_STAT, CL_OTHER
    } cmd_class_e;

    typedef enum logic [2:0] {
        SL_CMD, SL_DUP, SL_WSTRIPE, SL_RSTRIPE, SL_RSTAT, SL_RLOW
    } slot_e;

    // Sort an opcode into its handling class; never returns CL_NONE.
    function automatic cmd_class_e classify(input logic [7:0] op);
        case (op)
            8'h03, 8'h13:                      return CL_RD_A;
            8'h0B, 8'h0C, 8'h6B, 8'hEB:        return CL_RD_B;
            8'h02, 8'h12, 8'h32:               return CL_PROG;
            8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7: return CL_ERASE;
            8'h05, 8'h70:                      return CL_STAT;
            default:                           return CL_OTHER;
        endcase
    endfunction

    // Index of the final serial clock of a slot (clock count minus one).
    function automatic logic [2:0] slot_last(input slot_e s);
        case (s)
            SL_CMD:                  return 3'd7;
            SL_WSTRIPE, SL_RSTRIPE:  return 3'd0;
            default:                 return 3'd1;
        endcase
    endfunction

    function automatic logic is_read_slot(input slot_e s);
        return (s == SL_RSTRIPE) || (s == SL_RSTAT) || (s == SL_RLOW);
    endfunction

    // Even bits of a byte, lane k carrying bit 2k.
    function automatic logic [LANES-1:0] even_bits(input logic [7:0] b);
        return {b[6], b[4], b[2], b[0]};
    endfunction

    // Odd bits of a byte, lane k carrying bit 2k+1.
    function automatic logic [LANES-1:0] odd_bits(input logic [7:0] b);
        return {b[7], b[5], b[3], b[1]};
    endfunction

    // Rebuild a byte from the two devices' lanes in the split order.
    function automatic logic [7:0] weave(input logic [LANES-1:0] lo,
                                         input logic [LANES-1:0] hi);
        return {hi[3], lo[3], hi[2], lo[2], hi[1], lo[1], hi[0], lo[0]};
    endfunction

endpackage

// File: rtl/dpr_cmd_latch.sv
// Holds the class of the opcode of the frame in progress.
// Assumes load and clear never coincide (load only while idle).
module dpr_cmd_latch
    import dpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] opcode,
    input  logic       clear,
    output cmd_class_e cls
);

    // Capture the class at frame open, drop it at frame close.
    always_ff @(posedge clk) begin
        if (!rst_n)      cls <= CL_NONE;
        else if (clear)  cls <= CL_NONE;
        else if (load)   cls <= classify(opcode);
    end

    a_r10_clear_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cls == CL_NONE));
    a_r10_load_sets_class: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cls != CL_NONE));

endmodule

// File: rtl/dpr_sequencer.sv
// Frame and slot sequencer: accepts stream bytes, picks each byte's slot
// kind from the latched class, runs serial clock periods of two system
// clocks (low then high), inserts dummy clocks and drives chip select.
// Assumes ADDR_BYTES >= 1.
module dpr_sequencer
    import dpr_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DUMMY_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    input  logic [7:0]         tx_data,
    input  logic               tx_first,
    input  logic               tx_last,
    input  logic               tx_rd,
    output logic               tx_ready,
    input  logic [DUMMY_W-1:0] cfg_dummy_a,
    input  logic [DUMMY_W-1:0] cfg_dummy_b,
    input  cmd_class_e         cls,
    output logic               load_op,
    output logic               clear_op,
    output logic               cs_n,
    output logic               sck,
    output logic               slot_act,
    output logic               dummy_act,
    output slot_e              slot,
    output logic [2:0]         cnt_lo,
    output logic [7:0]         byte_o,
    output logic               sample,
    output logic               done
);

    localparam int CNT_W = (DUMMY_W + 1 > 3) ? DUMMY_W + 1 : 3;
    localparam int NB_W  = $clog2(ADDR_BYTES + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_DUMMY, ST_GAP} state_e;

    state_e             state;
    logic               ph;
    logic [CNT_W-1:0]   cnt;
    logic               last_r;
    logic [NB_W-1:0]    nbytes;
    logic               cs_n_r;
    slot_e              nxt_slot;
    logic               addr_phase;
    logic               is_rd_cls;
    logic [DUMMY_W-1:0] dsel;
    logic               dummy_go;

    // Slot kind for the next post-opcode byte, from class and byte index.
    always_comb begin
        addr_phase = int'(nbytes) < ADDR_BYTES;
        case (cls)
            CL_RD_A, CL_RD_B: nxt_slot = addr_phase ? SL_DUP : SL_RSTRIPE;
            CL_PROG:          nxt_slot = addr_phase ? SL_DUP : SL_WSTRIPE;
            CL_STAT:          nxt_slot = SL_RSTAT;
            CL_OTHER:         nxt_slot = tx_rd ? SL_RLOW : SL_DUP;
            default:          nxt_slot = SL_DUP;
        endcase
    end

    // Dummy insertion decision at the end of the final address slot.
    always_comb begin
        is_rd_cls = (cls == CL_RD_A) || (cls == CL_RD_B);
        dsel      = (cls == CL_RD_A) ? cfg_dummy_a : cfg_dummy_b;
        dummy_go  = is_rd_cls && (slot == SL_DUP) && (int'(nbytes) == ADDR_BYTES)
                    && !last_r && (dsel != '0);
    end

    // Handshake and strobes seen by the other pieces.
    always_comb begin
        tx_ready  = (state == ST_IDLE) || (state == ST_GAP);
        load_op   = (state == ST_IDLE) && tx_valid && tx_first;
        slot_act  = (state == ST_SLOT);
        dummy_act = (state == ST_DUMMY);
        sample    = slot_act && ph;
        done      = sample && (cnt == '0);
        clear_op  = done && last_r;
        sck       = ph && (slot_act || dummy_act);
        cs_n      = cs_n_r;
        cnt_lo    = cnt[2:0];
    end

    // Main frame state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cs_n_r <= 1'b1;
            ph     <= 1'b0;
            cnt    <= '0;
            slot   <= SL_CMD;
            byte_o <= '0;
            last_r <= 1'b0;
            nbytes <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tx_valid && tx_first) begin
                        byte_o <= tx_data;
                        slot   <= SL_CMD;
                        cnt    <= CNT_W'(slot_last(SL_CMD));
                        ph     <= 1'b0;
                        last_r <= tx_last;
                        nbytes <= '0;
                        cs_n_r <= 1'b0;
                        state  <= ST_SLOT;
                    end
                end
                ST_GAP: begin
                    if (tx_valid) begin
                        byte_o <= tx_data;
                        slot   <= nxt_slot;
                        cnt    <= CNT_W'(slot_last(nxt_slot));
                        ph     <= 1'b0;
                        last_r <= tx_last;
                        if (addr_phase) nbytes <= nbytes + 1'b1;
                        state  <= ST_SLOT;
                    end
                end
                ST_SLOT: begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else if (last_r) begin
                            cs_n_r <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (dummy_go) begin
                            cnt   <= CNT_W'({dsel, 1'b0}) - 1'b1;
                            state <= ST_DUMMY;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (cnt != '0) cnt <= cnt - 1'b1;
                        else           state <= ST_GAP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r1_open_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_r) |-> $past(tx_valid && tx_first));
    a_r10_ready_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_r) |-> tx_ready);

endmodule

// File: rtl/dpr_lane_map.sv
// Maps the current slot's byte onto the two devices' lanes.
// Assumes the byte and slot stay steady for the whole slot.
module dpr_lane_map
    import dpr_pkg::*;
(
    input  logic             act,
    input  slot_e            slot,
    input  logic [2:0]       cnt_lo,
    input  logic [7:0]       byte_i,
    output logic [LANES-1:0] lo_o,
    output logic [LANES-1:0] lo_oe,
    output logic [LANES-1:0] hi_o,
    output logic [LANES-1:0] hi_oe
);

    // Lane values and enables per slot kind; everything released otherwise.
    always_comb begin
        lo_o  = '0;
        hi_o  = '0;
        lo_oe = '0;
        hi_oe = '0;
        if (act) begin
            case (slot)
                SL_CMD: begin
                    lo_o  = {3'b000, byte_i[cnt_lo]};
                    hi_o  = {3'b000, byte_i[cnt_lo]};
                    lo_oe = 4'b0001;
                    hi_oe = 4'b0001;
                end
                SL_DUP: begin
                    lo_o  = cnt_lo[0] ? byte_i[7:4] : byte_i[3:0];
                    hi_o  = cnt_lo[0] ? byte_i[7:4] : byte_i[3:0];
                    lo_oe = 4'b1111;
                    hi_oe = 4'b1111;
                end
                SL_WSTRIPE: begin
                    lo_o  = even_bits(byte_i);
                    hi_o  = odd_bits(byte_i);
                    lo_oe = 4'b1111;
                    hi_oe = 4'b1111;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dpr_rx_merge.sv
// Samples device lanes during read slots and builds the returned byte:
// rebuilt from the split, ORed across devices, or lower device only.
// Assumes two-clock slots present the high nibble first.
module dpr_rx_merge
    import dpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             done,
    input  slot_e            slot,
    input  logic [LANES-1:0] lo_i,
    input  logic [LANES-1:0] hi_i,
    output logic             rx_valid,
    output logic [7:0]       rx_data
);

    logic [LANES-1:0] lo_h;
    logic [LANES-1:0] hi_h;

    // Hold first nibbles, then emit the merged byte when the slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_h     <= '0;
            hi_h     <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sample && !done) begin
                lo_h <= lo_i;
                hi_h <= hi_i;
            end
            if (done && is_read_slot(slot)) begin
                rx_valid <= 1'b1;
                case (slot)
                    SL_RSTRIPE: rx_data <= weave(lo_i, hi_i);
                    SL_RSTAT:   rx_data <= {lo_h | hi_h, lo_i | hi_i};
                    default:    rx_data <= {lo_h, lo_i};
                endcase
            end
        end
    end

    a_r5_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/dpr_router.sv
// Top of the dual-parallel flash command router: latches the opcode class,
// sequences slots, maps lanes and merges returned bytes.
// Assumes both devices are identical and wired to one chip select and clock.
module dpr_router
    import dpr_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DUMMY_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [7:0]         tx_data,
    input  logic               tx_first,
    input  logic               tx_last,
    input  logic               tx_rd,
    input  logic [DUMMY_W-1:0] cfg_dummy_a,
    input  logic [DUMMY_W-1:0] cfg_dummy_b,
    output logic               cs_n,
    output logic               sck,
    output logic [3:0]         lo_dq_o,
    output logic [3:0]         lo_dq_oe,
    input  logic [3:0]         lo_dq_i,
    output logic [3:0]         hi_dq_o,
    output logic [3:0]         hi_dq_oe,
    input  logic [3:0]         hi_dq_i,
    output logic               rx_valid,
    output logic [7:0]         rx_data
);

    cmd_class_e cls;
    slot_e      slot;
    logic       load_op;
    logic       clear_op;
    logic       slot_act;
    logic       dummy_act;
    logic [2:0] cnt_lo;
    logic [7:0] cur_byte;
    logic       sample;
    logic       done;

    dpr_cmd_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_op),
        .opcode (tx_data),
        .clear  (clear_op),
        .cls    (cls)
    );

    dpr_sequencer #(
        .ADDR_BYTES (ADDR_BYTES),
        .DUMMY_W    (DUMMY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_first    (tx_first),
        .tx_last     (tx_last),
        .tx_rd       (tx_rd),
        .tx_ready    (tx_ready),
        .cfg_dummy_a (cfg_dummy_a),
        .cfg_dummy_b (cfg_dummy_b),
        .cls         (cls),
        .load_op     (load_op),
        .clear_op    (clear_op),
        .cs_n        (cs_n),
        .sck         (sck),
        .slot_act    (slot_act),
        .dummy_act   (dummy_act),
        .slot        (slot),
        .cnt_lo      (cnt_lo),
        .byte_o      (cur_byte),
        .sample      (sample),
        .done        (done)
    );

    dpr_lane_map u_map (
        .act    (slot_act),
        .slot   (slot),
        .cnt_lo (cnt_lo),
        .byte_i (cur_byte),
        .lo_o   (lo_dq_o),
        .lo_oe  (lo_dq_oe),
        .hi_o   (hi_dq_o),
        .hi_oe  (hi_dq_oe)
    );

    dpr_rx_merge u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .done     (done),
        .slot     (slot),
        .lo_i     (lo_dq_i),
        .hi_i     (hi_dq_i),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    a_r1_sck_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
    a_r6_dummy_released: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_act |-> (lo_dq_oe == 4'b0000 && hi_dq_oe == 4'b0000));
    a_r2_cmd_lane0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_act && slot == SL_CMD) |-> (lo_dq_oe == 4'b0001 && hi_dq_oe == 4'b0001));

endmodule

// File: tb/test_dpr_router.sv
module test_dpr_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = '0;
    logic       tx_first = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_rd = 1'b0;
    logic [3:0] cfg_dummy_a = '0;
    logic [3:0] cfg_dummy_b = '0;
    logic       cs_n;
    logic       sck;
    logic [3:0] lo_dq_o, lo_dq_oe, hi_dq_o, hi_dq_oe;
    logic [3:0] lo_dq_i = '0;
    logic [3:0] hi_dq_i = '0;
    logic       rx_valid;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dpr_router i_dpr_router (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last), .tx_rd(tx_rd),
        .cfg_dummy_a(cfg_dummy_a), .cfg_dummy_b(cfg_dummy_b), .cs_n(cs_n), .sck(sck),
        .lo_dq_o(lo_dq_o), .lo_dq_oe(lo_dq_oe), .lo_dq_i(lo_dq_i),
        .hi_dq_o(hi_dq_o), .hi_dq_oe(hi_dq_oe), .hi_dq_i(hi_dq_i),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // Capture of lane state at each serial clock high, and returned bytes.
    logic [15:0] cap [0:511];
    logic [7:0]  rx_got [0:511];
    logic [7:0]  tb_buf [0:511];
    bit          tb_rd [0:511];
    int          rcnt = 0;
    int          frame_rises = 0;
    int          rx_n = 0;
    int          tot_rise = 0;
    bit          cs_seen_low = 0;

    function automatic logic [3:0] dev_lo(input int r);
        return 4'(r * 5 + 3);
    endfunction

    function automatic logic [3:0] dev_hi(input int r);
        return 4'(r * 11 + 6);
    endfunction

    // Device model and monitor, all at the falling system clock edge.
    always @(negedge clk) begin
        if (!cs_n) cs_seen_low = 1;
        if (cs_n) begin
            if (rcnt != 0) frame_rises = rcnt;
            rcnt = 0;
        end else if (sck) begin
            if (rcnt < 512) cap[rcnt] = {lo_dq_o, lo_dq_oe, hi_dq_o, hi_dq_oe};
            rcnt++;
            tot_rise++;
        end
        if (rx_valid && rx_n < 512) begin
            rx_got[rx_n] = rx_data;
            rx_n++;
        end
        if (!sck) begin
            lo_dq_i = dev_lo(rcnt);
            hi_dq_i = dev_hi(rcnt);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit f, input bit l, input bit rd);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        tx_first = f;
        tx_last  = l;
        tx_rd    = rd;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
        tx_first = 1'b0;
        tx_last  = 1'b0;
        tx_rd    = 1'b0;
    endtask

    task automatic frame(input logic [7:0] op, input int n);
        @(posedge clk);
        #1;
        rx_n = 0;
        put(op, 1'b1, n == 0, 1'b0);
        for (int j = 0; j < n; j++) put(tb_buf[j], 1'b0, j == n - 1, tb_rd[j]);
        @(negedge clk);
        while (!cs_n) @(negedge clk);
        chk(tx_ready === 1'b1, "R10 ready at close", int'(tx_ready), 1);
        repeat (2) @(negedge clk);
    endtask

    function automatic int tb_cls(input logic [7:0] op);
        case (op)
            8'h03, 8'h13:                      return 1;
            8'h0B, 8'h0C, 8'h6B, 8'hEB:        return 2;
            8'h02, 8'h12, 8'h32:               return 3;
            8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7: return 4;
            8'h05, 8'h70:                      return 5;
            default:                           return 6;
        endcase
    endfunction

    function automatic logic [7:0] tb_weave(input logic [3:0] lo, input logic [3:0] hi);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            b[2*k]   = lo[k];
            b[2*k+1] = hi[k];
        end
        return b;
    endfunction

    task automatic chk_rise(input int r, input logic [15:0] exp, input string tag);
        chk(cap[r] === exp, tag, int'(cap[r]), int'(exp));
    endtask

    // Expected lane pattern and returned bytes, walked from the requirements.
    task automatic chk_frame(input logic [7:0] op, input int n);
        int r = 0;
        int k = 0;
        int c = tb_cls(op);
        int d = (c == 1) ? int'(cfg_dummy_a) : int'(cfg_dummy_b);
        for (int i = 7; i >= 0; i--) begin
            chk_rise(r, {3'b000, op[i], 4'b0001, 3'b000, op[i], 4'b0001}, "R2 opcode lane0");
            r++;
        end
        for (int j = 0; j < n; j++) begin
            logic [7:0] b = tb_buf[j];
            bit addr = (j < 3);
            if (((c == 1 || c == 2 || c == 3) && addr) || c == 4 || (c == 6 && !tb_rd[j])) begin
                string tg = (c == 4) ? "R7 erase dup" : (c == 6) ? "R9 other dup" : "R3 addr dup";
                chk_rise(r,     {b[7:4], 4'hF, b[7:4], 4'hF}, tg);
                chk_rise(r + 1, {b[3:0], 4'hF, b[3:0], 4'hF}, tg);
                r += 2;
                if ((c == 1 || c == 2) && j == 2 && n > 3) begin
                    for (int q = 0; q < 2 * d; q++) begin
                        chk_rise(r, 16'h0000, "R6 dummy released");
                        r++;
                    end
                end
            end else if (c == 1 || c == 2) begin
                chk_rise(r, 16'h0000, "R5 read released");
                chk(rx_got[k] === tb_weave(dev_lo(r), dev_hi(r)), "R5 read rebuild",
                    int'(rx_got[k]), int'(tb_weave(dev_lo(r), dev_hi(r))));
                r++;
                k++;
            end else if (c == 3) begin
                chk_rise(r, {b[6], b[4], b[2], b[0], 4'hF, b[7], b[5], b[3], b[1], 4'hF},
                         tb_rd[j] ? "R11 rd ignored on program" : "R4 program split");
                r++;
            end else if (c == 5) begin
                logic [7:0] e = {dev_lo(r) | dev_hi(r), dev_lo(r + 1) | dev_hi(r + 1)};
                chk_rise(r, 16'h0000, "R8 status released");
                chk_rise(r + 1, 16'h0000, "R8 status released");
                chk(rx_got[k] === e, "R8 status OR", int'(rx_got[k]), int'(e));
                r += 2;
                k++;
            end else begin
                logic [7:0] e = {dev_lo(r), dev_lo(r + 1)};
                chk_rise(r, 16'h0000, "R9 other read released");
                chk(rx_got[k] === e, "R9 lower only", int'(rx_got[k]), int'(e));
                r += 2;
                k++;
            end
        end
        chk(frame_rises == r, "R10 clock count per frame", frame_rises, r);
        chk(rx_n == k, "R5 returned byte count", rx_n, k);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R12 reset state
        chk(cs_n === 1'b1, "R12 cs_n", int'(cs_n), 1);
        chk(sck === 1'b0, "R12 sck", int'(sck), 0);
        chk({lo_dq_oe, hi_dq_oe} === 8'h00, "R12 oe", int'({lo_dq_oe, hi_dq_oe}), 0);
        chk(rx_valid === 1'b0, "R12 rx_valid", int'(rx_valid), 0);
        chk(tx_ready === 1'b1, "R12 tx_ready", int'(tx_ready), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: a byte without the start mark while idle is dropped
        put(8'h02, 1'b0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(cs_seen_low == 0, "R1 no frame without start", int'(cs_seen_low), 0);
        chk(tot_rise == 0, "R1 no clock without start", tot_rise, 0);

        // R2/R10: opcode-only frame of an unclassified command
        frame(8'h06, 0);
        chk_frame(8'h06, 0);

        // R3/R4/R11: program with every data byte value
        tb_buf[0] = 8'hA5; tb_buf[1] = 8'h3C; tb_buf[2] = 8'hF0;
        for (int j = 0; j < 256; j++) begin
            tb_buf[j + 3] = 8'(j);
            tb_rd[j + 3]  = (j % 5 == 0);
        end
        frame(8'h02, 259);
        chk_frame(8'h02, 259);
        for (int j = 0; j < 512; j++) tb_rd[j] = 0;

        // R5/R6: reads of both classes across dummy counts
        for (int d = 0; d < 4; d++) begin
            cfg_dummy_a = 4'(d);
            cfg_dummy_b = 4'(3 - d);
            for (int j = 0; j < 19; j++) tb_buf[j] = 8'(j * 37 + d);
            frame(8'h03, 19);
            chk_frame(8'h03, 19);
            frame(8'h6B, 19);
            chk_frame(8'h6B, 19);
        end

        // R7: erase with address and chip erase
        tb_buf[0] = 8'h12; tb_buf[1] = 8'hE7; tb_buf[2] = 8'h5A;
        frame(8'hD8, 3);
        chk_frame(8'hD8, 3);
        frame(8'hC7, 0);
        chk_frame(8'hC7, 0);

        // R8/R11: status reads, read flag toggled
        for (int j = 0; j < 4; j++) tb_rd[j] = j[0];
        frame(8'h05, 4);
        chk_frame(8'h05, 4);
        frame(8'h70, 2);
        chk_frame(8'h70, 2);

        // R9: unclassified opcode mixing writes and reads
        tb_buf[0] = 8'h81; tb_buf[1] = 8'h7E; tb_buf[2] = 8'hC3;
        tb_buf[3] = 8'h1F; tb_buf[4] = 8'hB4; tb_buf[5] = 8'h69;
        tb_rd[0] = 1; tb_rd[1] = 0; tb_rd[2] = 1; tb_rd[3] = 1; tb_rd[4] = 0; tb_rd[5] = 1;
        frame(8'h9F, 6);
        chk_frame(8'h9F, 6);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule